// File: doc/BRIEF.md
# DDR SDRAM Start-up Command Sequencer

This block owns the DRAM command bus from reset until the memory is ready for normal traffic. After reset it keeps the clock-enable low and the bus deselected for a programmable settling time. It then raises clock-enable and walks a fixed series of commands: an extended mode write that turns the DLL on, a base mode write that resets the DLL, a precharge of every bank, two auto refreshes and, when enabled, a last base mode write that clears the DLL reset bit. Between commands it counts programmable wait intervals and drives only NOP. When the series is complete and the DLL has had enough clocks to lock, it raises `ready` and keeps the bus idle so that the normal controller can take over.

The wait lengths, burst length, burst type, CAS latency and the optional final write come in as inputs. They are expected to be held steady from reset release until `ready`. Reserved burst-length and CAS-latency codes are replaced by safe legal values, so the DRAM never receives a reserved setting. All bus outputs are registered.

Top module: `ddr_init_seq`

## Requirements
- R1: From reset and for max(stab_cycles,1)+1 cycles after reset release, `cke` is 0, `ready` is 0 and `cmd` is DESELECT (4'b1111). A synchronous reset at any time returns the block to this state.
- R2: `cmd` is {cs_n, ras_n, cas_n, we_n}. NOP is 4'b0111, mode write is 4'b0000, precharge is 4'b0010 and auto refresh is 4'b0001. Every cycle after `cke` rises that does not carry one of the listed commands is NOP.
- R3: `cke` rises together with one NOP cycle, which directly precedes the first command. `cke` then stays high until reset.
- R4: The first command is a mode write with `ba`=2'b01 and `addr` all zeros (bit 0 = 0 enables the DLL, bit 1 = 0 selects normal drive). It is followed by max(mrd_cycles,1) NOP cycles.
- R5: Next comes a mode write with `ba`=2'b00 whose `addr` holds the burst-length code in [2:0], the burst type in [3], the CAS code in [6:4], a 1 in bit 8 (DLL reset) and zeros elsewhere. It is followed by max(mrd_cycles,1) NOP cycles.
- R6: Next comes a precharge with `addr`[10]=1 (all banks), other `addr` bits 0 and `ba`=0, followed by max(rp_cycles,1) NOPs. Then come two auto refreshes, each followed by max(rfc_cycles,1) NOPs.
- R7: When `final_mr_en` is 1, a further mode write with `ba`=2'b00 repeats the R5 word with bit 8 cleared and is followed by max(mrd_cycles,1) NOPs. When it is 0, this step is skipped.
- R8: `ready` rises in the first cycle that both follows the last wait and lies at least LOCK_CYC cycles after the DLL-reset mode write. Any cycles in between carry NOP.
- R9: Once high, `ready` stays high with `cmd`=NOP and `cke`=1 until reset.
- R10: A CAS code other than 3'b010, 3'b011 or 3'b110 is sent as 3'b110 in both base mode writes.
- R11: A burst-length code other than 3'b001, 3'b010 or 3'b011 is sent as 3'b010 in both base mode writes.
- R12: A wait input of zero is treated as one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stab_cycles | input | STAB_W | Settling cycles with clock-enable low |
| mrd_cycles | input | WAIT_W | NOP cycles after each mode write |
| rp_cycles | input | WAIT_W | NOP cycles after the precharge |
| rfc_cycles | input | WAIT_W | NOP cycles after each refresh |
| bl_code | input | 3 | Burst-length code |
| burst_type | input | 1 | Burst type bit |
| cl_code | input | 3 | CAS-latency code |
| final_mr_en | input | 1 | Enables the closing mode write |
| cmd | output | 4 | {cs_n, ras_n, cas_n, we_n} |
| ba | output | BA_W | Bank address |
| addr | output | ADDR_W | Address bus |
| cke | output | 1 | Clock enable |
| ready | output | 1 | Start-up complete |

## Verification
The properties assume that the wait lengths, mode fields and the final-write enable stay constant between reset release and `ready`. They also assume LOCK_CYC is at least 2, so that the lock window measured on the bus is meaningful. The stimulus changes these inputs only while reset is held low, and it cuts some runs short with a fresh reset rather than by changing an input partway through a sequence.

// File: rtl/ddr_init_pkg.sv
// Shared definitions for the DDR start-up sequencer: command codes,
// mode-word bit positions, step encoding and code sanitisers.
// Assumes command encoding {cs_n, ras_n, cas_n, we_n}.
package ddr_init_pkg;

    localparam logic [3:0] CMD_DESEL = 4'b1111;
    localparam logic [3:0] CMD_NOP   = 4'b0111;
    localparam logic [3:0] CMD_LMR   = 4'b0000;
    localparam logic [3:0] CMD_PRE   = 4'b0010;
    localparam logic [3:0] CMD_REF   = 4'b0001;

    localparam int MR_BL_LSB  = 0;
    localparam int MR_BT_BIT  = 3;
    localparam int MR_CL_LSB  = 4;
    localparam int MR_DLL_RST = 8;
    localparam int PRE_ALL    = 10;
    localparam int EMR_DLL_DIS = 0;
    localparam int EMR_DRV_RED = 1;

    localparam logic [1:0] BA_EXT  = 2'b01;
    localparam logic [1:0] BA_BASE = 2'b00;

    typedef enum logic [3:0] {
        ST_STAB, ST_CKE, ST_EMR, ST_W_EMR,
        ST_MR_RST, ST_W_MR, ST_PRE, ST_W_PRE,
        ST_REF1, ST_W_REF1, ST_REF2, ST_W_REF2,
        ST_MR_FIN, ST_W_FIN, ST_LOCK, ST_READY
    } step_e;

    // Replace a reserved CAS-latency code by 2.5 (R10)
    function automatic logic [2:0] fix_cas(input logic [2:0] c);
        case (c)
            3'b010, 3'b011, 3'b110: return c;
            default:                return 3'b110;
        endcase
    endfunction

    // Replace a reserved burst-length code by length 4 (R11)
    function automatic logic [2:0] fix_bl(input logic [2:0] b);
        case (b)
            3'b001, 3'b010, 3'b011: return b;
            default:                return 3'b010;
        endcase
    endfunction

endpackage

// File: rtl/init_wait_timer.sv
// Step timer: counts cycles spent in the current step and flags when the
// requested length has been reached. A limit of zero counts as one.
// Assumes restart is pulsed on the last cycle of every step.
module init_wait_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [CNT_W-1:0] limit,
    output logic             done
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W:0]   eff_limit;

    // Cycle counter inside one step, saturating
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            cnt <= '0;
        end else if (cnt != CNT_MAX) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Minimum length one, compare elapsed cycles to the limit
    always_comb begin
        eff_limit = (limit == '0) ? (CNT_W+1)'(1) : {1'b0, limit};
        done      = ({1'b0, cnt} + (CNT_W+1)'(1)) >= eff_limit;
    end
endmodule

// File: rtl/init_lock_timer.sv
// DLL lock timer: started by the DLL-reset step, it reports locked once
// the next cycle is at least LOCK_CYC cycles after that step.
// Assumes LOCK_CYC >= 2 and one start pulse per sequence.
module init_lock_timer #(
    parameter int LOCK_CYC = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic locked
);
    localparam int LK_W = $clog2(LOCK_CYC + 1);
    localparam logic [LK_W-1:0] LK_LAST = LK_W'(LOCK_CYC - 1);

    logic [LK_W-1:0] cnt;

    // Cycles elapsed since the DLL reset, held at the lock point
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= LK_W'(1);
        end else if (cnt != '0 && cnt < LK_LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Lock point reached
    always_comb locked = (cnt >= LK_LAST);
endmodule

// File: rtl/init_mode_word.sv
// Mode-word builder: forms the extended word (DLL on, normal drive) and
// the two base words (DLL reset set / cleared) from sanitised settings.
// Assumes ADDR_W >= 11.
module init_mode_word
    import ddr_init_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  logic [2:0]        bl_code,
    input  logic              burst_type,
    input  logic [2:0]        cl_code,
    output logic [ADDR_W-1:0] emr_word,
    output logic [ADDR_W-1:0] mr_rst_word,
    output logic [ADDR_W-1:0] mr_run_word
);
    logic [ADDR_W-1:0] base;

    // Operating fields shared by both base words
    always_comb begin
        base = '0;
        base[MR_BL_LSB +: 3] = fix_bl(bl_code);
        base[MR_BT_BIT]      = burst_type;
        base[MR_CL_LSB +: 3] = fix_cas(cl_code);
    end

    // Final words
    always_comb begin
        emr_word              = '0;
        emr_word[EMR_DLL_DIS] = 1'b0;
        emr_word[EMR_DRV_RED] = 1'b0;
        mr_rst_word             = base;
        mr_rst_word[MR_DLL_RST] = 1'b1;
        mr_run_word             = base;
        mr_run_word[MR_DLL_RST] = 1'b0;
    end
endmodule

// File: rtl/ddr_init_seq.sv
// DDR start-up sequencer top: walks settle, clock-enable, extended mode,
// DLL-reset mode, precharge-all, two refreshes and an optional closing
// mode write, with NOP waits between, then raises ready once the DLL has
// had LOCK_CYC cycles. Outputs are registered (one cycle after the step).
// Assumes all setting inputs are stable from reset release until ready.
module ddr_init_seq
    import ddr_init_pkg::*;
#(
    parameter int ADDR_W   = 13,
    parameter int BA_W     = 2,
    parameter int STAB_W   = 16,
    parameter int WAIT_W   = 8,
    parameter int LOCK_CYC = 200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAB_W-1:0] stab_cycles,
    input  logic [WAIT_W-1:0] mrd_cycles,
    input  logic [WAIT_W-1:0] rp_cycles,
    input  logic [WAIT_W-1:0] rfc_cycles,
    input  logic [2:0]        bl_code,
    input  logic              burst_type,
    input  logic [2:0]        cl_code,
    input  logic              final_mr_en,
    output logic [3:0]        cmd,
    output logic [BA_W-1:0]   ba,
    output logic [ADDR_W-1:0] addr,
    output logic              cke,
    output logic              ready
);
    localparam int TMR_W = (STAB_W > WAIT_W) ? STAB_W : WAIT_W;

    step_e             state_q, state_d;
    logic              step_done, locked;
    logic [TMR_W-1:0]  step_limit;
    logic [ADDR_W-1:0] emr_word, mr_rst_word, mr_run_word;
    logic [3:0]        cmd_d;
    logic [BA_W-1:0]   ba_d;
    logic [ADDR_W-1:0] addr_d;
    logic              cke_d, ready_d;
    step_e             after_waits;

    // Length of the current wait step
    always_comb begin
        case (state_q)
            ST_STAB:                      step_limit = TMR_W'(stab_cycles);
            ST_W_EMR, ST_W_MR, ST_W_FIN:  step_limit = TMR_W'(mrd_cycles);
            ST_W_PRE:                     step_limit = TMR_W'(rp_cycles);
            ST_W_REF1, ST_W_REF2:         step_limit = TMR_W'(rfc_cycles);
            default:                      step_limit = '0;
        endcase
    end

    // Step that follows the last wait: ready if locked, else lock wait
    always_comb after_waits = locked ? ST_READY : ST_LOCK;

    // Step sequencing
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_STAB:   if (step_done) state_d = ST_CKE;
            ST_CKE:    state_d = ST_EMR;
            ST_EMR:    state_d = ST_W_EMR;
            ST_W_EMR:  if (step_done) state_d = ST_MR_RST;
            ST_MR_RST: state_d = ST_W_MR;
            ST_W_MR:   if (step_done) state_d = ST_PRE;
            ST_PRE:    state_d = ST_W_PRE;
            ST_W_PRE:  if (step_done) state_d = ST_REF1;
            ST_REF1:   state_d = ST_W_REF1;
            ST_W_REF1: if (step_done) state_d = ST_REF2;
            ST_REF2:   state_d = ST_W_REF2;
            ST_W_REF2: if (step_done) state_d = final_mr_en ? ST_MR_FIN : after_waits;
            ST_MR_FIN: state_d = ST_W_FIN;
            ST_W_FIN:  if (step_done) state_d = after_waits;
            ST_LOCK:   if (locked) state_d = ST_READY;
            default:   state_d = ST_READY;
        endcase
    end

    // Step register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_STAB;
        else        state_q <= state_d;
    end

    init_wait_timer #(.CNT_W(TMR_W)) u_wait (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (state_d != state_q),
        .limit   (step_limit),
        .done    (step_done)
    );

    init_lock_timer #(.LOCK_CYC(LOCK_CYC)) u_lock (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (state_q == ST_MR_RST),
        .locked (locked)
    );

    init_mode_word #(.ADDR_W(ADDR_W)) u_word (
        .bl_code     (bl_code),
        .burst_type  (burst_type),
        .cl_code     (cl_code),
        .emr_word    (emr_word),
        .mr_rst_word (mr_rst_word),
        .mr_run_word (mr_run_word)
    );

    // Bus value for the current step
    always_comb begin
        cmd_d   = CMD_NOP;
        ba_d    = '0;
        addr_d  = '0;
        cke_d   = 1'b1;
        ready_d = 1'b0;
        case (state_q)
            ST_STAB: begin
                cmd_d = CMD_DESEL;
                cke_d = 1'b0;
            end
            ST_EMR: begin
                cmd_d  = CMD_LMR;
                ba_d   = BA_W'(BA_EXT);
                addr_d = emr_word;
            end
            ST_MR_RST: begin
                cmd_d  = CMD_LMR;
                ba_d   = BA_W'(BA_BASE);
                addr_d = mr_rst_word;
            end
            ST_MR_FIN: begin
                cmd_d  = CMD_LMR;
                ba_d   = BA_W'(BA_BASE);
                addr_d = mr_run_word;
            end
            ST_PRE: begin
                cmd_d           = CMD_PRE;
                addr_d[PRE_ALL] = 1'b1;
            end
            ST_REF1, ST_REF2: cmd_d = CMD_REF;
            ST_READY:         ready_d = 1'b1;
            default:          cmd_d = CMD_NOP;
        endcase
    end

    // Registered bus outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd   <= CMD_DESEL;
            ba    <= '0;
            addr  <= '0;
            cke   <= 1'b0;
            ready <= 1'b0;
        end else begin
            cmd   <= cmd_d;
            ba    <= ba_d;
            addr  <= addr_d;
            cke   <= cke_d;
            ready <= ready_d;
        end
    end
endmodule

// File: rtl/ddr_init_chk.sv
// Protocol checker for the start-up sequencer, bound to its top module.
// Watches only the bus ports; keeps its own count of cycles since the
// DLL-reset mode write. Assumes LOCK_CYC >= 2 and stable setting inputs.
module ddr_init_chk
    import ddr_init_pkg::*;
#(
    parameter int ADDR_W   = 13,
    parameter int BA_W     = 2,
    parameter int LOCK_CYC = 200
) (
    input logic              clk,
    input logic              rst_n,
    input logic [3:0]        cmd,
    input logic [BA_W-1:0]   ba,
    input logic [ADDR_W-1:0] addr,
    input logic              cke,
    input logic              ready
);
    localparam int LK_W = $clog2(LOCK_CYC + 1) + 1;

    logic [LK_W-1:0] since_rst;
    logic            lmr_ext, lmr_base, is_cmd;

    // Classify the bus value
    always_comb begin
        lmr_ext  = (cmd == CMD_LMR) && (ba == BA_W'(BA_EXT));
        lmr_base = (cmd == CMD_LMR) && (ba == BA_W'(BA_BASE));
        is_cmd   = (cmd != CMD_NOP) && (cmd != CMD_DESEL);
    end

    // Cycles since the DLL-reset mode write, saturating at LOCK_CYC
    always_ff @(posedge clk) begin
        if (!rst_n) since_rst <= '0;
        else if (lmr_base && addr[MR_DLL_RST]) since_rst <= LK_W'(1);
        else if (since_rst != '0 && since_rst < LK_W'(LOCK_CYC)) since_rst <= since_rst + 1'b1;
    end

    assert_deselect_cke_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |-> (cmd == CMD_DESEL && !ready));

    assert_nop_after_command_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cke && is_cmd) |=> (cmd == CMD_NOP));

    assert_cke_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cke |=> cke);

    assert_ext_word_dll_on_R4: assert property (@(posedge clk) disable iff (!rst_n)
        lmr_ext |-> (addr == '0));

    assert_lock_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> (since_rst >= LK_W'(LOCK_CYC)));

    assert_ready_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> (ready && cmd == CMD_NOP));

    assert_cas_legal_R10: assert property (@(posedge clk) disable iff (!rst_n)
        lmr_base |-> (addr[MR_CL_LSB +: 3] == 3'b010 || addr[MR_CL_LSB +: 3] == 3'b011 ||
                      addr[MR_CL_LSB +: 3] == 3'b110));

    assert_bl_legal_R11: assert property (@(posedge clk) disable iff (!rst_n)
        lmr_base |-> (addr[MR_BL_LSB +: 3] == 3'b001 || addr[MR_BL_LSB +: 3] == 3'b010 ||
                      addr[MR_BL_LSB +: 3] == 3'b011));
endmodule

bind ddr_init_seq ddr_init_chk #(
    .ADDR_W   (ADDR_W),
    .BA_W     (BA_W),
    .LOCK_CYC (LOCK_CYC)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .cmd   (cmd),
    .ba    (ba),
    .addr  (addr),
    .cke   (cke),
    .ready (ready)
);

// File: tb/test_ddr_init_seq.sv
// Bench: builds the expected bus trace of every run from the requirements
// and compares it cycle by cycle. Directed corners plus seeded random runs.
`timescale 1ns/1ps
module test_ddr_init_seq;
    localparam int ADDR_W = 13;
    localparam int BA_W   = 2;
    localparam int STAB_W = 16;
    localparam int WAIT_W = 8;
    localparam int LOCK   = 200;
    localparam int MAXC   = 4096;

    localparam logic [3:0] C_DES = 4'b1111;
    localparam logic [3:0] C_NOP = 4'b0111;
    localparam logic [3:0] C_LMR = 4'b0000;
    localparam logic [3:0] C_PRE = 4'b0010;
    localparam logic [3:0] C_REF = 4'b0001;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [STAB_W-1:0] stab_cycles = '0;
    logic [WAIT_W-1:0] mrd_cycles = '0, rp_cycles = '0, rfc_cycles = '0;
    logic [2:0]        bl_code = 3'b010, cl_code = 3'b010;
    logic              burst_type = 1'b0, final_mr_en = 1'b1;
    logic [3:0]        cmd;
    logic [BA_W-1:0]   ba;
    logic [ADDR_W-1:0] addr;
    logic              cke, ready;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [3:0]        e_cmd  [MAXC];
    logic [BA_W-1:0]   e_ba   [MAXC];
    logic [ADDR_W-1:0] e_addr [MAXC];
    logic              e_cke  [MAXC];
    logic              e_rdy  [MAXC];
    string             e_tag  [MAXC];
    int                n_exp;

    always #10 clk = ~clk;

    ddr_init_seq #(
        .ADDR_W(ADDR_W), .BA_W(BA_W), .STAB_W(STAB_W), .WAIT_W(WAIT_W), .LOCK_CYC(LOCK)
    ) i_ddr_init_seq (
        .clk(clk), .rst_n(rst_n), .stab_cycles(stab_cycles), .mrd_cycles(mrd_cycles),
        .rp_cycles(rp_cycles), .rfc_cycles(rfc_cycles), .bl_code(bl_code),
        .burst_type(burst_type), .cl_code(cl_code), .final_mr_en(final_mr_en),
        .cmd(cmd), .ba(ba), .addr(addr), .cke(cke), .ready(ready)
    );

    function automatic int eff(input int v);
        return (v == 0) ? 1 : v;           // R12
    endfunction

    function automatic logic [2:0] exp_cl(input logic [2:0] c);
        return (c == 3'b010 || c == 3'b011 || c == 3'b110) ? c : 3'b110;   // R10
    endfunction

    function automatic logic [2:0] exp_bl(input logic [2:0] b);
        return (b == 3'b001 || b == 3'b010 || b == 3'b011) ? b : 3'b010;   // R11
    endfunction

    function automatic logic [ADDR_W-1:0] mode_word(input logic [2:0] b, input logic t,
                                                    input logic [2:0] c, input logic dll);
        return {4'b0000, dll, 1'b0, exp_cl(c), t, exp_bl(b)};              // R5
    endfunction

    task automatic push(input logic [3:0] c, input logic [BA_W-1:0] b,
                        input logic [ADDR_W-1:0] a, input logic k, input logic r,
                        input string t);
        if (n_exp < MAXC) begin
            e_cmd[n_exp] = c; e_ba[n_exp] = b; e_addr[n_exp] = a;
            e_cke[n_exp] = k; e_rdy[n_exp] = r; e_tag[n_exp] = t;
            n_exp++;
        end
    endtask

    task automatic push_nops(input int cnt, input string t);
        for (int i = 0; i < cnt; i++) push(C_NOP, '0, '0, 1'b1, 1'b0, t);
    endtask

    task automatic build(input int st, input int md, input int rp, input int rf,
                         input logic [2:0] b, input logic t, input logic [2:0] c,
                         input logic fin);
        int t_dll;
        n_exp = 0;
        for (int i = 0; i < eff(st) + 1; i++) push(C_DES, '0, '0, 1'b0, 1'b0, "R1");
        push(C_NOP, '0, '0, 1'b1, 1'b0, "R3");
        push(C_LMR, 2'b01, '0, 1'b1, 1'b0, "R4");
        push_nops(eff(md), "R2 R12");
        t_dll = n_exp;
        push(C_LMR, 2'b00, mode_word(b, t, c, 1'b1), 1'b1, 1'b0, "R5 R10 R11");
        push_nops(eff(md), "R2 R12");
        push(C_PRE, '0, 13'h400, 1'b1, 1'b0, "R6");
        push_nops(eff(rp), "R2 R12");
        push(C_REF, '0, '0, 1'b1, 1'b0, "R6");
        push_nops(eff(rf), "R2 R12");
        push(C_REF, '0, '0, 1'b1, 1'b0, "R6");
        push_nops(eff(rf), "R2 R12");
        if (fin) begin
            push(C_LMR, 2'b00, mode_word(b, t, c, 1'b0), 1'b1, 1'b0, "R7 R10 R11");
            push_nops(eff(md), "R7");
        end
        while (n_exp < t_dll + LOCK) push(C_NOP, '0, '0, 1'b1, 1'b0, "R8");
        for (int i = 0; i < 6; i++) push(C_NOP, '0, '0, 1'b1, 1'b1, "R8 R9");
    endtask

    task automatic run(input int st, input int md, input int rp, input int rf,
                       input logic [2:0] b, input logic t, input logic [2:0] c,
                       input logic fin, input int cut);
        int lim;
        @(negedge clk);
        rst_n       = 1'b0;
        stab_cycles = STAB_W'(st);
        mrd_cycles  = WAIT_W'(md);
        rp_cycles   = WAIT_W'(rp);
        rfc_cycles  = WAIT_W'(rf);
        bl_code     = b;
        burst_type  = t;
        cl_code     = c;
        final_mr_en = fin;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        build(st, md, rp, rf, b, t, c, fin);
        lim = (cut > 0 && cut < n_exp) ? cut : n_exp;
        for (int i = 0; i < lim; i++) begin
            if (i > 0) @(negedge clk);
            checks++;
            if (cmd !== e_cmd[i] || ba !== e_ba[i] || addr !== e_addr[i] ||
                cke !== e_cke[i] || ready !== e_rdy[i]) begin
                errors++;
                $display("FAIL %s cycle %0d: cmd=%b ba=%b addr=%h cke=%b ready=%b expected cmd=%b ba=%b addr=%h cke=%b ready=%b",
                         e_tag[i], i, cmd, ba, addr, cke, ready,
                         e_cmd[i], e_ba[i], e_addr[i], e_cke[i], e_rdy[i]);
            end
        end
    endtask

    initial begin
        void'($urandom(32'd4242));
        // R1 R5: typical settings, closing write on
        run(20, 2, 3, 10, 3'b011, 1'b0, 3'b010, 1'b1, 0);
        // R12: every wait zero, closing write off (R7 skip)
        run(0, 0, 0, 0, 3'b001, 1'b0, 3'b011, 1'b0, 0);
        // R8: waits outlast the lock window so ready follows the last wait
        run(5, 40, 40, 130, 3'b010, 1'b1, 3'b110, 1'b1, 0);
        // R10 R11: reserved codes
        run(3, 1, 2, 4, 3'b111, 1'b1, 3'b101, 1'b1, 0);
        run(3, 1, 2, 4, 3'b000, 1'b0, 3'b000, 1'b0, 0);
        // R1: reset partway through, then a clean run
        run(4, 2, 2, 6, 3'b010, 1'b0, 3'b010, 1'b1, 15);
        run(4, 2, 2, 6, 3'b010, 1'b0, 3'b010, 1'b1, 0);
        // Seeded random runs
        for (int k = 0; k < 24; k++) begin
            int cut;
            cut = ($urandom_range(0, 5) == 0) ? int'($urandom_range(1, 60)) : 0;
            run(int'($urandom_range(0, 300)), int'($urandom_range(0, 6)),
                int'($urandom_range(0, 8)), int'($urandom_range(0, 40)),
                3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)),
                3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)), cut);
        end
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not end, actual running expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule